// File: doc/BRIEF.md
# Timestamp Timer with Selectable Timebase

This block keeps a free-running timestamp for a host. A counter of `CNT_W` bits advances on ticks derived from the 50 MHz system clock. One of three timebases can be selected: a fine base that counts nanoseconds in steps of 20 (one step per system clock), a microsecond base, and a millisecond base. The host reaches the block through a plain read/write strobe bus with two registers. One holds the timebase code and a hold-at-zero bit. The other returns the current count.

A control state machine tracks the configuration. Its states are `TS_FINE`, `TS_MICRO` and `TS_MILLI` (counting), `TS_HOLD` (count pinned at zero) and `TS_PARKED` (unsupported code, count frozen). Reset enters `TS_FINE`. The state changes only on a configuration write, and the written word picks the next state. A set hold bit leads to `TS_HOLD`. Otherwise code 0 leads to `TS_FINE`, code 1 to `TS_MICRO`, code 2 to `TS_MILLI`, and any other code to `TS_PARKED`. Software zeroes the timestamp by writing its chosen code with the hold bit set, then writing the same code with the bit clear.

Top module: `stamp_timer`

## Requirements
- R1: After reset the count is 0, the configuration reads 0, and the block counts in the fine timebase.
- R2: A write to `CFG_ADDR` stores bits 7:0 as the timebase code and bit 8 as the hold bit. A read of `CFG_ADDR` returns these same bits in the same positions, with all other bits zero.
- R3: When `bus_rd` is high at a clock edge, `bus_rdata` takes at that edge the selected register's value from just before the edge. The count is zero-extended to `DATA_W`. Without a read strobe, `bus_rdata` keeps its value.
- R4: With code 0 the count rises by `FINE_STEP` (20) on every clock.
- R5: With code 1 the count rises by 1 once every `US_DIV` clocks. With code 2 it rises by 1 once every `MS_DIV` clocks.
- R6: Every configuration write restarts the tick prescaler. The edge that takes the write never adds to the count. The first increment comes exactly one full timebase period after that edge.
- R7: A configuration write with bit 8 set zeroes the count at its own edge. The count stays zero until a write clears bit 8, and counting then follows R6.
- R8: A code above 2 (hold bit clear) freezes the count at its current value. A later valid code resumes counting from that value.
- R9: The count wraps modulo 2^`CNT_W`.
- R10: Writes to `CNT_ADDR` or to any unmapped address change neither register. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for the read or write |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench shrinks the count to 12 bits and the dividers to `US_DIV`=5 and `MS_DIV`=13, while keeping the fine step of 20. With these values a fine-mode wrap arrives after about 205 clocks, so R9 can be checked directly. The exact tick edge of every timebase can also be probed, one cycle before and at the first increment. The bench sweeps all three valid codes and several spacings between reads, and it also covers mid-period reprogramming, parked codes, and bus writes to the read-only or unmapped addresses. Its model is an arithmetic expression in the number of clock edges since the last configuration write.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    // Control states; the counting states come first
    typedef enum logic [2:0] {
        TS_FINE   = 3'd0,
        TS_MICRO  = 3'd1,
        TS_MILLI  = 3'd2,
        TS_HOLD   = 3'd3,
        TS_PARKED = 3'd4
    } ts_state_e;

    localparam int unsigned SRC_W   = 8;   // timebase code field, bits 7:0
    localparam int unsigned CLR_BIT = 8;   // hold-at-zero bit
    localparam int unsigned MAX_SRC = 2;   // highest supported code
endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
    import tsr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 cfg_wr_o,
    output logic                 zero_o,
    output logic [SRC_W-1:0]     src_o,
    output logic                 clr_o,
    output ts_state_e            state_o,
    output logic                 run_o,
    output logic                 fine_o
);
    ts_state_e          state_q, state_d;
    logic [SRC_W-1:0]   src_q;
    logic               clr_q;
    logic               cfg_wr;
    logic [SRC_W-1:0]   wsrc;
    logic               wclr;

    assign cfg_wr = bus_wr && (bus_addr == CFG_ADDR);
    assign wsrc   = bus_wdata[SRC_W-1:0];
    assign wclr   = bus_wdata[CLR_BIT];

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            clr_q <= 1'b0;
        end else if (cfg_wr) begin
            src_q <= wsrc;
            clr_q <= wclr;
        end
    end

    // next-state selection, taken only on a configuration write
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            if (wclr) begin
                state_d = TS_HOLD;
            end else begin
                unique case (wsrc)
                    8'd0:    state_d = TS_FINE;
                    8'd1:    state_d = TS_MICRO;
                    8'd2:    state_d = TS_MILLI;
                    default: state_d = TS_PARKED;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_FINE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        run_o  = 1'b0;
        fine_o = 1'b0;
        unique case (state_q)
            TS_FINE:   begin run_o = 1'b1; fine_o = 1'b1; end
            TS_MICRO:  run_o = 1'b1;
            TS_MILLI:  run_o = 1'b1;
            TS_HOLD:   run_o = 1'b0;
            TS_PARKED: run_o = 1'b0;
            default:   run_o = 1'b0;
        endcase
    end

    assign cfg_wr_o = cfg_wr;
    assign zero_o   = (cfg_wr && wclr) || (state_q == TS_HOLD);
    assign src_o    = src_q;
    assign clr_o    = clr_q;
    assign state_o  = state_q;

    assert_hold_has_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_HOLD) |-> clr_q);
    assert_parked_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_PARKED) |-> (!clr_q && (src_q > SRC_W'(MAX_SRC))));
    assert_state_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(state_q));
endmodule

// File: rtl/tsr_prescale.sv
module tsr_prescale
    import tsr_pkg::*;
#(
    parameter int unsigned US_DIV = 50,
    parameter int unsigned MS_DIV = 50000,
    localparam int unsigned MAX_DIV = (US_DIV > MS_DIV) ? US_DIV : MS_DIV,
    localparam int unsigned PRE_W   = $clog2(MAX_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ts_state_e  state_i,
    input  logic       run_i,
    input  logic       restart_i,
    output logic       tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             last;

    always_comb begin
        unique case (state_i)
            TS_FINE:  limit = PRE_W'(1);
            TS_MICRO: limit = PRE_W'(US_DIV);
            TS_MILLI: limit = PRE_W'(MS_DIV);
            default:  limit = PRE_W'(1);
        endcase
    end

    assign last   = (pre_q == (limit - PRE_W'(1)));
    assign tick_o = run_i && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pre_q <= '0;
        else if (restart_i || !run_i) pre_q <= '0;
        else if (last)               pre_q <= '0;
        else                         pre_q <= pre_q + PRE_W'(1);
    end

    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pre_q == '0));
    assert_pre_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (pre_q < limit));
endmodule

// File: rtl/tsr_counter.sv
module tsr_counter #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned FINE_STEP = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fine_i,
    input  logic             zero_i,
    input  logic             freeze_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;

    assign step = fine_i ? CNT_W'(FINE_STEP) : CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (zero_i)   cnt_q <= '0;
        else if (freeze_i) cnt_q <= cnt_q;
        else if (tick_i)   cnt_q <= cnt_q + step;
    end

    assign cnt_o = cnt_q;

    assert_zero_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (cnt_q == '0));
    assert_frozen_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !zero_i) |=> $stable(cnt_q));
    assert_no_step_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !zero_i) |=> $stable(cnt_q));
    assert_fine_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && fine_i && !freeze_i && !zero_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(FINE_STEP)));
endmodule

// File: rtl/tsr_readback.sv
module tsr_readback #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned CFG_W  = 9,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h600,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h602
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        if (bus_addr == CNT_ADDR)      sel = DATA_W'(cnt_i);
        else if (bus_addr == CFG_ADDR) sel = DATA_W'(cfg_i);
        else                           sel = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= sel;
    end

    assign rdata_o = rdata_q;

    assert_rdata_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != CNT_ADDR && bus_addr != CFG_ADDR) |=> (rdata_q == '0));
endmodule

// File: rtl/stamp_timer.sv
module stamp_timer
    import tsr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned US_DIV    = 50,
    parameter int unsigned MS_DIV    = 50000,
    parameter int unsigned FINE_STEP = 20,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h600,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h602,
    localparam int unsigned CFG_W = CLR_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    logic             cfg_wr, zero, clr, run, fine, tick;
    logic [SRC_W-1:0] src;
    ts_state_e        state;
    logic [CNT_W-1:0] cnt;

    tsr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cfg_wr_o(cfg_wr), .zero_o(zero), .src_o(src),
        .clr_o(clr), .state_o(state), .run_o(run), .fine_o(fine)
    );

    tsr_prescale #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .state_i(state), .run_i(run),
        .restart_i(cfg_wr), .tick_o(tick)
    );

    tsr_counter #(.CNT_W(CNT_W), .FINE_STEP(FINE_STEP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .fine_i(fine), .zero_i(zero),
        .freeze_i(cfg_wr), .run_i(run), .cnt_o(cnt)
    );

    tsr_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_W(CFG_W),
                   .CFG_ADDR(CFG_ADDR), .CNT_ADDR(CNT_ADDR)) u_rb (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .cnt_i(cnt), .cfg_i({clr, src}), .rdata_o(bus_rdata)
    );

    assert_rst_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == TS_FINE));
endmodule

// File: tb/sim_stamp_timer.sv
`timescale 1ns/1ps
module sim_stamp_timer;
    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W = 12, DATA_W = 32, CNT_W = 12;
    localparam int US_DIV = 5, MS_DIV = 13, FINE_STEP = 20;
    localparam logic [11:0] CFG_A = 12'h600, CNT_A = 12'h602, BAD_A = 12'h604;
    localparam longint MASK = (longint'(1) << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    longint cyc = 0;
    longint m_base = 0, m_w = 0;
    int m_step = FINE_STEP, m_div = 1, m_cfg = 0;
    bit m_run = 1'b1;

    stamp_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .US_DIV(US_DIV),
                  .MS_DIV(MS_DIV), .FINE_STEP(FINE_STEP), .CFG_ADDR(CFG_A),
                  .CNT_ADDR(CNT_A)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint model_now();
        longint n = cyc - m_w;
        if (!m_run) return m_base;
        return (m_base + longint'(m_step) * (n / m_div)) & MASK;
    endfunction

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, int d);
        longint held = model_now();
        bus_addr = a; bus_wdata = DATA_W'(d); bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        if (a == CFG_A) begin
            m_cfg = d & 'h1FF;
            m_w = cyc;
            if (d[8]) begin m_base = 0; m_run = 1'b0; end
            else if ((d & 'hFF) <= 2) begin
                m_base = held; m_run = 1'b1;
                m_step = ((d & 'hFF) == 0) ? FINE_STEP : 1;
                m_div = ((d & 'hFF) == 0) ? 1 : (((d & 'hFF) == 1) ? US_DIV : MS_DIV);
            end else begin m_base = held; m_run = 1'b0; end
        end
    endtask

    task automatic rd(logic [11:0] a, output longint v);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        v = longint'(bus_rdata);
    endtask

    task automatic chk_count(string req);
        longint e = model_now();
        longint v;
        rd(CNT_A, v);
        check(req, v, e);
    endtask

    task automatic chk_cfg(string req);
        longint v;
        rd(CFG_A, v);
        check(req, v, longint'(m_cfg));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        longint v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; m_w = cyc;
        chk_count("R1 count after reset");
        chk_cfg("R1 config after reset");
        for (int k = 0; k < 4; k++) begin idle(k); chk_count("R4 fine from reset"); end

        // sweep over the three valid timebases
        for (int s = 0; s <= 2; s++) begin
            int d = (s == 0) ? 1 : ((s == 1) ? US_DIV : MS_DIV);
            wr(CFG_A, 'h100 | s);
            chk_count("R7 zero on hold write");
            chk_cfg("R2 readback with hold bit");
            idle(2 * d + 3);
            chk_count("R7 held at zero");
            wr(CFG_A, s);
            chk_cfg("R2 readback code");
            idle(d - 1);
            chk_count("R6 no tick before full period");
            chk_count("R6 first tick at full period");
            for (int j = 0; j < 6; j++) begin
                idle(3 * j + 1);
                chk_count(s == 0 ? "R4 fine step" : "R5 divided step");
            end
        end

        // restart mid-period with the same code
        wr(CFG_A, 1);
        idle(3);
        wr(CFG_A, 1);
        idle(US_DIV - 1);
        chk_count("R6 restart mid-period");
        chk_count("R6 tick after restart");

        // parked codes
        wr(CFG_A, 7);
        idle(30);
        chk_count("R8 frozen on code 7");
        chk_cfg("R2 readback code 7");
        wr(CFG_A, 'hFF);
        idle(20);
        chk_count("R8 frozen on code 255");
        wr(CFG_A, 2);
        idle(MS_DIV * 2);
        chk_count("R8 resume from held value");
        chk_count("R3 zero-extended count read");

        // wrap in fine mode
        wr(CFG_A, 'h100); wr(CFG_A, 0);
        idle(200);
        chk_count("R9 before wrap");
        idle(10);
        chk_count("R9 after wrap");

        // ignored writes, unmapped reads
        wr(CNT_A, 'h123);
        chk_count("R10 count write ignored");
        chk_cfg("R10 config kept after count write");
        wr(BAD_A, 'h105);
        chk_cfg("R10 config kept after unmapped write");
        chk_count("R10 counting kept after unmapped write");
        rd(BAD_A, v);
        check("R10 unmapped read", v, 0);
        // rdata holds without strobe
        idle(5);
        check("R3 rdata held", longint'(bus_rdata), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule